// File: doc/BRIEF.md
# DS3 Nibble-Wide Payload Serializer

This block turns payload supplied four bits at a time into a serial DS3 line bit stream. It counts bit positions inside each 85-bit DS3 block. Position 0 is the overhead slot, and the bit on the overhead input goes onto the line there. The other 84 positions carry payload. In nibble mode the payload is 21 nibbles per block. Each nibble is requested by a one-cycle strobe, and the nibble grid restarts at the first payload bit after every overhead bit, so no nibble crosses an overhead slot.

The four input lanes are not in plain binary order. Lane 2 holds the most significant bit, then lane 1, then lane 0, and lane 3 holds the least significant bit. The least significant lane is captured in a dedicated flip-flop, enabled by the strobe, and that flip-flop feeds the last bit of the nibble. This removes the one-bit slip that a plain serial path would add to that lane.

Nibble mode needs both the nibble enable and the payload-interface disable to be set, with E3 operation not selected. In every other case the block passes a bit-serial payload input straight through and still inserts the overhead bit.

Top module: `ds3_nib_ser`

## Requirements
- R1: After reset the block position counter starts at 0 and advances by one each clock. It wraps from 84 to 0. `ovh_slot` is high exactly in the cycles where the position is 0.
- R2: When nibble mode is off, `ser_out` in the next cycle equals `ovh_in` for position 0 and `ser_in` for every other position, and `nib_req` stays low.
- R3: In nibble mode `nib_req` is high for one cycle at positions 1, 5, 9, …, 81, giving 21 strobes per block, and is low everywhere else.
- R4: `nib_req` is never high in the overhead slot, and the nibble grid restarts at position 1 of every block.
- R5: `ser_out` is registered. The value it shows in cycle t+1 is the line bit for the position of cycle t.
- R6: The nibble sampled in a strobe cycle goes out over four consecutive payload positions in this order: `nib_in[2]`, `nib_in[1]`, `nib_in[0]`, `nib_in[3]`.
- R7: All lanes, including lane 3 through its skew flip-flop, are captured only in strobe cycles. Changes on `nib_in` in other cycles do not alter `ser_out`.
- R8: Nibble mode is on only when `nib_en`=1 and `pay_dis`=1 and `e3_mode`=0. Setting `e3_mode`=1 forces serial operation as in R2.
- R9: Synchronous active-high `rst` clears the counter, the shift state, the skew flip-flop and `ser_out`. In nibble mode `ser_out` stays 0 until the first nibble is loaded, so the first overhead slot after reset goes out as 0.
- R10: In nibble mode, once a nibble has been loaded, the overhead slot carries `ovh_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_en | input | 1 | Nibble mode enable |
| pay_dis | input | 1 | Bit-serial payload interface disable |
| e3_mode | input | 1 | E3 operation selected (forces serial) |
| ovh_in | input | 1 | Overhead bit for the current block slot |
| ser_in | input | 1 | Bit-serial payload input (serial mode) |
| nib_in | input | 4 | Nibble lanes (2=MSB, 1, 0, 3=LSB) |
| nib_req | output | 1 | Nibble request strobe |
| ovh_slot | output | 1 | Current position is the overhead slot |
| ser_out | output | 1 | Serial line data, registered |

## Verification
The case that is hardest to expose from the ports is a lane latched in the wrong cycle. The LSB reaches the line three positions after its strobe, so a skew flip-flop that keeps loading after the strobe, or loads a cycle late, looks correct as long as the nibble input is held steady. To catch this, the stimulus puts fresh random values on all four lanes in every cycle. A correct serial stream is then possible only if each lane was taken at the strobe. Each mode combination, including E3 with both enables set, is started from its own reset, so the unprimed overhead slot is also checked.

// File: rtl/ds3_nib_pkg.sv
package ds3_nib_pkg;

  // Nibble phase for the next cycle: an overhead slot reloads the grid
  // so that the following payload bit starts at phase 0.
  function automatic logic [1:0] phase_step(input logic in_ovh, input logic [1:0] ph);
    return in_ovh ? 2'd0 : ph + 2'd1;
  endfunction

  // Nibble operation needs both enables and must never run on E3.
  function automatic logic nib_mode_on(input logic en, input logic dis, input logic e3);
    return en & dis & ~e3;
  endfunction

  // Line bit for a slot in nibble mode: gated to 0 until primed.
  function automatic logic nib_line_bit(input logic in_ovh, input logic primed,
                                        input logic ovh_bit, input logic pay_bit);
    if (!primed) return 1'b0;
    return in_ovh ? ovh_bit : pay_bit;
  endfunction

endpackage

// File: rtl/ds3_blk_ctr.sv
module ds3_blk_ctr #(
  parameter int BLK_LEN = 85,
  localparam int POS_W = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic [1:0]       phase,
  output logic             ovh,
  output logic             last
);
  import ds3_nib_pkg::*;

  assign ovh  = (pos == '0);
  assign last = (pos == POS_W'(BLK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      phase <= 2'd0;
    end else begin
      pos   <= last ? '0 : pos + 1'b1;
      phase <= phase_step(ovh, phase);
    end
  end
endmodule

// File: rtl/ds3_lane_shift.sv
module ds3_lane_shift #(
  parameter int NIB_W    = 4,
  parameter int MSB_LANE = 2,
  parameter int SB2_LANE = 1,
  parameter int SB3_LANE = 0,
  parameter int LSB_LANE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NIB_W-1:0] nib_in,
  input  logic [1:0]       phase,
  output logic             pay_bit,
  output logic             lsb_q
);
  logic [1:0] mid_q;

  // Middle lanes shift MSB first; the LSB lane has its own strobe-enabled
  // flop that supplies the fourth bit and cancels the one-bit slip.
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q <= 2'b00;
      lsb_q <= 1'b0;
    end else if (load) begin
      mid_q <= {nib_in[SB2_LANE], nib_in[SB3_LANE]};
      lsb_q <= nib_in[LSB_LANE];
    end else begin
      mid_q <= {mid_q[0], 1'b0};
    end
  end

  always_comb begin
    unique case (phase)
      2'd0:    pay_bit = nib_in[MSB_LANE];
      2'd1:    pay_bit = mid_q[1];
      2'd2:    pay_bit = mid_q[1];
      default: pay_bit = lsb_q;
    endcase
  end
endmodule

// File: rtl/ds3_nib_ser.sv
module ds3_nib_ser #(
  parameter int BLK_LEN = 85,
  parameter int NIB_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nib_en,
  input  logic             pay_dis,
  input  logic             e3_mode,
  input  logic             ovh_in,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             nib_req,
  output logic             ovh_slot,
  output logic             ser_out
);
  import ds3_nib_pkg::*;

  localparam int POS_W = $clog2(BLK_LEN);

  logic [POS_W-1:0] pos;
  logic [1:0]       phase;
  logic             last;
  logic             nib_act;
  logic             pay_bit;
  logic             lsb_q;
  logic             primed_q;
  logic             nxt_bit;

  ds3_blk_ctr #(.BLK_LEN(BLK_LEN)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .pos   (pos),
    .phase (phase),
    .ovh   (ovh_slot),
    .last  (last)
  );

  assign nib_act = nib_mode_on(nib_en, pay_dis, e3_mode);
  assign nib_req = nib_act && !ovh_slot && (phase == 2'd0);

  ds3_lane_shift #(.NIB_W(NIB_W)) u_lane (
    .clk     (clk),
    .rst     (rst),
    .load    (nib_req),
    .nib_in  (nib_in),
    .phase   (phase),
    .pay_bit (pay_bit),
    .lsb_q   (lsb_q)
  );

  always_comb begin
    if (nib_act)
      nxt_bit = nib_line_bit(ovh_slot, primed_q | nib_req, ovh_in, pay_bit);
    else
      nxt_bit = ovh_slot ? ovh_in : ser_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      ser_out  <= 1'b0;
    end else begin
      primed_q <= primed_q | nib_req;
      ser_out  <= nxt_bit;
    end
  end
endmodule

// File: rtl/ds3_nib_ser_chk.sv
module ds3_nib_ser_chk #(
  parameter int BLK_LEN = 85,
  parameter int NIB_W   = 4,
  localparam int POS_W = $clog2(BLK_LEN)
) (
  input logic             clk,
  input logic             rst,
  input logic             e3_mode,
  input logic             ser_in,
  input logic [NIB_W-1:0] nib_in,
  input logic             nib_req,
  input logic             ovh_slot,
  input logic             ser_out,
  input logic [POS_W-1:0] pos,
  input logic [1:0]       phase,
  input logic             nib_act,
  input logic             lsb_q
);
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos < POS_W'(BLK_LEN)); // R1
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(BLK_LEN - 1)) |=> (pos == '0)); // R1
  AST_REQ_NOT_OVH: assert property (@(posedge clk) disable iff (rst)
    ovh_slot |-> !nib_req); // R4
  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (rst)
    nib_req |=> !nib_req); // R3
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (nib_act && pos == POS_W'(1)) |-> nib_req); // R4
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_W'(1)) |-> (phase == 2'd0)); // R4
  AST_E3_SERIAL: assert property (@(posedge clk) disable iff (rst)
    e3_mode |-> !nib_req); // R8
  AST_LSB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    nib_req |=> (lsb_q == $past(nib_in[3]))); // R7
  AST_LSB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !nib_req |=> $stable(lsb_q)); // R7
  AST_SERIAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (!nib_act && !ovh_slot) |=> (ser_out == $past(ser_in))); // R2
endmodule

bind ds3_nib_ser ds3_nib_ser_chk #(.BLK_LEN(BLK_LEN), .NIB_W(NIB_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .e3_mode  (e3_mode),
  .ser_in   (ser_in),
  .nib_in   (nib_in),
  .nib_req  (nib_req),
  .ovh_slot (ovh_slot),
  .ser_out  (ser_out),
  .pos      (pos),
  .phase    (phase),
  .nib_act  (nib_act),
  .lsb_q    (lsb_q)
);

// File: tb/ds3_nib_ser_test.sv
module ds3_nib_ser_test;
  localparam int CLK_PER = 10;
  localparam int BLK = 85;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nib_en = 1'b0, pay_dis = 1'b0, e3_mode = 1'b0;
  logic       ovh_in = 1'b0, ser_in = 1'b0;
  logic [3:0] nib_in = 4'h0;
  logic       nib_req, ovh_slot, ser_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  int         mpos;
  bit         primed;
  logic [3:0] cur;

  always #(CLK_PER/2) clk = ~clk;

  ds3_nib_ser uut (
    .clk(clk), .rst(rst), .nib_en(nib_en), .pay_dis(pay_dis), .e3_mode(e3_mode),
    .ovh_in(ovh_in), .ser_in(ser_in), .nib_in(nib_in),
    .nib_req(nib_req), .ovh_slot(ovh_slot), .ser_out(ser_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b (pos %0d)", tag, act, exp, mpos);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Reset with a mode: R9 reset state checked when rst drops.
  task automatic do_reset(input logic en, input logic dis, input logic e3);
    @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    nib_en = en; pay_dis = dis; e3_mode = e3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mpos = 0; primed = 1'b0; cur = 4'h0;
    check("R9 ser_out after reset", ser_out, 1'b0);
    check("R1 ovh_slot after reset", ovh_slot, 1'b1);
  endtask

  // Driver: one cycle at the current negedge, pushes the expected line bit.
  task automatic step();
    logic       mact, b, ereq;
    logic [3:0] n;
    logic       o, s;
    int         k;
    n = 4'($urandom);
    o = 1'($urandom);
    s = 1'($urandom);
    mact = nib_en & pay_dis & ~e3_mode;
    ereq = mact && mpos != 0 && ((mpos - 1) % 4 == 0);
    check(mact ? "R3 nib_req" : "R8 nib_req off", nib_req, ereq);
    check("R1 ovh_slot", ovh_slot, mpos == 0);
    nib_in = n; ovh_in = o; ser_in = s;
    if (!mact) begin
      b = (mpos == 0) ? o : s;
      tag_q.push_back(e3_mode ? "R8 serial out" : "R2 serial out");
    end else if (mpos == 0) begin
      b = primed ? o : 1'b0;
      tag_q.push_back(primed ? "R10 overhead" : "R9 unprimed overhead");
    end else begin
      k = (mpos - 1) % 4;
      if (k == 0) begin cur = n; primed = 1'b1; end
      case (k)
        0: b = cur[2];
        1: b = cur[1];
        2: b = cur[0];
        default: b = cur[3];
      endcase
      tag_q.push_back(k == 3 ? "R7 lsb lane" : "R6 lane order");
    end
    exp_q.push_back(b);
    mpos = (mpos == BLK - 1) ? 0 : mpos + 1;
    @(negedge clk);
  endtask

  // Monitor: R5, the registered bit appears after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, ser_out, e);
      end
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    do_reset(1'b1, 1'b1, 1'b0);
    repeat (4 * BLK + 7) step();
    do_reset(1'b0, 1'b1, 1'b0);
    repeat (BLK + 3) step();
    do_reset(1'b1, 1'b0, 1'b0);
    repeat (BLK + 3) step();
    do_reset(1'b1, 1'b1, 1'b1);
    repeat (BLK + 3) step();
    do_reset(1'b1, 1'b1, 1'b0);
    repeat (2 * BLK) step();
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule